// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command front end of a small flash store. A host drives chip-enable, output-enable, write-enable, an address and a data byte. Each write strobe with the chip selected delivers a command byte to a decoder. The decoder holds the read mode, which is one of array contents, the status register or the identifier codes. It also passes program and erase requests to a timed write engine that works on a register-file array. The status register shows whether the engine is ready and holds the error flags. A programming-voltage-OK input decides whether commands that change the array are accepted.

All inputs are sampled on a single system clock. A write strobe is detected when write-enable rises while chip-enable is low, and the command or data byte present at that clock edge is taken. The read path is combinational from the address and the registered mode.

Top module: `flash_cmd_if`

## Requirements
- R1: After synchronous reset the block is in array-read mode, every array word reads as all ones, and the status register reads 0x80.
- R2: data_oe is high only when rst is low, we_n is high, ce_n is low and oe_n is low. Whenever data_oe is low, data_o is zero.
- R3: Writing 0xFF while the engine is idle selects array-read mode from any other mode.
- R4: Writing 0x70 selects status-read mode. The status byte has the ready flag at bit 7, the erase/sequence error at bit 5, the program error at bit 4 and the voltage-lockout error at bit 3. All other bits are zero.
- R5: Writing 0x90 selects identifier mode. Address 0 reads the manufacturer code (default 0xA5), address 1 reads the device code (default 0x3C), and any other address reads zero.
- R6: Writing 0x40 and then a data byte programs the addressed word with old AND data. Ready reads 0 for PROG_CYC cycles. From the setup write onwards the block stays in status-read mode until 0xFF is written.
- R7: If the programmed word does not equal the data byte, bit 4 is set and stays set.
- R8: Writing 0x20 and then 0xD0 sets every word of the aligned BLK_WORDS block that holds the confirm address to all ones, after ERASE_CYC cycles. Any confirm byte other than 0xD0 sets bits 5 and 4 and leaves the array unchanged.
- R9: While vpp_ok is low, 0x40 and 0x20 do not change the array. Each sets bit 3 and selects status mode. The read, status, clear and identifier commands still work.
- R10: While the engine is busy, only 0x70 takes effect. Every other byte is ignored, 0xFF included.
- R11: Writing 0x50 while idle clears bits 5, 4 and 3.
- R12: A write-enable rise with ce_n high has no effect. Unknown command bytes in the idle state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a rising edge latches a byte |
| vpp_ok | input | 1 | Programming supply good; low means lockout |
| addr | input | AW | Word address |
| wdata | input | DW | Command or program data |
| data_o | output | DW | Read data, zero when not driven |
| data_oe | output | 1 | Read data valid and driven |

## Verification
The assertions assume the following about the inputs:
- Write-enable is held low for at least one clock before it rises, so each strobe yields exactly one rising edge.
- The address and data are steady at the clock edge where that rise is seen.
- vpp_ok is only changed while no setup command is pending.

The stimulus drives inputs one time unit after the falling clock edge. It keeps chip-enable low for the whole strobe and changes the supply input only between complete command sequences. The bench model also processes write strobes with chip-enable high and busy-time commands, so the ignore cases are compared on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_IDENT  = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2
    } seq_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic lock_err;
    } err_flags_t;

    localparam logic [7:0] CMD_ARRAY    = 8'hFF;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_CLEAR    = 8'h50;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_PROGRAM  = 8'h40;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

    function automatic logic [7:0] pack_status(input logic ready, input err_flags_t f);
        return {ready, 1'b0, f.erase_err, f.prog_err, f.lock_err, 3'b000};
    endfunction

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW  = 6,
    parameter int DW  = 8,
    parameter int BAW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    input  logic               ers_en,
    input  logic [AW-BAW-1:0]  ers_blk,
    input  logic [AW-1:0]      raddr,
    output logic [DW-1:0]      rdata,
    output logic [DW-1:0]      old_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                mem[i] <= '1;
            end else if (ers_en && ((AW-BAW)'(i >> BAW) == ers_blk)) begin
                mem[i] <= '1;
            end else if (wr_en && (waddr == AW'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata    = mem[raddr];
    assign old_word = mem[waddr];

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mem[$past(waddr)] & ~$past(old_word)) == '0)); // R7

    AST_ERASE_SETS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        ers_en |=> (mem[{$past(ers_blk), BAW'(0)}] == '1)); // R8

endmodule

// File: rtl/flash_write_engine.sv
module flash_write_engine
    import flash_cmd_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int BAW       = 4,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  op_e                start_op,
    input  logic [AW-1:0]      start_addr,
    input  logic [DW-1:0]      start_data,
    input  logic [DW-1:0]      old_word,
    output logic               busy,
    output logic               fin_fail,
    output logic               arr_wr,
    output logic [AW-1:0]      arr_addr,
    output logic [DW-1:0]      arr_wdata,
    output logic               arr_ers,
    output logic [AW-BAW-1:0]  arr_blk
);
    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            cnt    <= (start_op == OP_PROG) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
            op_q   <= start_op;
            addr_q <= start_addr;
            data_q <= start_data;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign finish    = busy && (cnt == '0);
    assign arr_addr  = addr_q;
    assign arr_wdata = old_word & data_q;
    assign arr_wr    = finish && (op_q == OP_PROG);
    assign arr_ers   = finish && (op_q == OP_ERASE);
    assign arr_blk   = addr_q[AW-1:BAW];
    assign fin_fail  = arr_wr && (arr_wdata != data_q);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R10

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R6

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce_n,
    input  logic           we_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic           vpp_ok,
    input  logic           busy,
    input  logic           fin_fail,
    output rd_mode_e       mode,
    output logic [7:0]     status,
    output logic           start,
    output op_e            start_op,
    output logic [AW-1:0]  start_addr,
    output logic [DW-1:0]  start_data
);
    logic       we_q;
    logic       evt;
    logic [7:0] cmd;
    rd_mode_e   mode_q, mode_n;
    seq_e       seq_q, seq_n;
    err_flags_t err_q, err_n;

    assign evt = we_n && !we_q && !ce_n;
    assign cmd = wdata[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b1;
            mode_q <= MODE_ARRAY;
            seq_q  <= SEQ_IDLE;
            err_q  <= '0;
        end else begin
            we_q   <= we_n;
            mode_q <= mode_n;
            seq_q  <= seq_n;
            err_q  <= err_n;
        end
    end

    always_comb begin
        mode_n   = mode_q;
        seq_n    = seq_q;
        err_n    = err_q;
        start    = 1'b0;
        start_op = OP_PROG;
        if (fin_fail) err_n.prog_err = 1'b1;
        if (evt) begin
            if (busy) begin
                if (cmd == CMD_STATUS) mode_n = MODE_STATUS;
            end else begin
                unique case (seq_q)
                    SEQ_PROG: begin
                        start  = 1'b1;
                        mode_n = MODE_STATUS;
                        seq_n  = SEQ_IDLE;
                    end
                    SEQ_ERASE: begin
                        if (cmd == CMD_CONFIRM) begin
                            start    = 1'b1;
                            start_op = OP_ERASE;
                        end else begin
                            err_n.erase_err = 1'b1;
                            err_n.prog_err  = 1'b1;
                        end
                        mode_n = MODE_STATUS;
                        seq_n  = SEQ_IDLE;
                    end
                    default: begin
                        case (cmd)
                            CMD_ARRAY:  mode_n = MODE_ARRAY;
                            CMD_STATUS: mode_n = MODE_STATUS;
                            CMD_IDENT:  mode_n = MODE_IDENT;
                            CMD_CLEAR:  err_n  = '0;
                            CMD_PROGRAM, CMD_ERASE: begin
                                mode_n = MODE_STATUS;
                                if (vpp_ok) seq_n = (cmd == CMD_PROGRAM) ? SEQ_PROG : SEQ_ERASE;
                                else        err_n.lock_err = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    assign mode       = mode_q;
    assign status     = pack_status(!busy, err_q);
    assign start_addr = addr;
    assign start_data = wdata;

    AST_LOCK_GATES_SETUP: assert property (@(posedge clk) disable iff (rst)
        (seq_q != SEQ_IDLE && $past(seq_q) == SEQ_IDLE) |-> $past(vpp_ok)); // R9

    AST_START_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode_q == MODE_STATUS)); // R6

    AST_BUSY_HOLDS_SEQ: assert property (@(posedge clk) disable iff (rst)
        (busy && evt) |=> (seq_q == $past(seq_q))); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q.prog_err && !(evt && !busy && seq_q == SEQ_IDLE && cmd == CMD_CLEAR))
        |=> err_q.prog_err); // R11

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int          AW        = 6,
    parameter int          DW        = 8,
    parameter int          BAW       = 4,
    parameter int          PROG_CYC  = 4,
    parameter int          ERASE_CYC = 20,
    parameter logic [7:0]  MFR_CODE  = 8'hA5,
    parameter logic [7:0]  DEV_CODE  = 8'h3C
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce_n,
    input  logic           oe_n,
    input  logic           we_n,
    input  logic           vpp_ok,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  data_o,
    output logic           data_oe
);
    rd_mode_e          mode;
    logic [7:0]        status;
    logic              start;
    op_e               start_op;
    logic [AW-1:0]     start_addr;
    logic [DW-1:0]     start_data;
    logic              busy, fin_fail;
    logic              arr_wr, arr_ers;
    logic [AW-1:0]     arr_addr;
    logic [DW-1:0]     arr_wdata, arr_rdata, old_word;
    logic [AW-BAW-1:0] arr_blk;
    logic [DW-1:0]     rd_val;

    flash_cmd_decoder #(.AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .vpp_ok(vpp_ok), .busy(busy), .fin_fail(fin_fail),
        .mode(mode), .status(status), .start(start), .start_op(start_op),
        .start_addr(start_addr), .start_data(start_data)
    );

    flash_write_engine #(.AW(AW), .DW(DW), .BAW(BAW),
                         .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
        .clk(clk), .rst(rst), .start(start), .start_op(start_op),
        .start_addr(start_addr), .start_data(start_data), .old_word(old_word),
        .busy(busy), .fin_fail(fin_fail), .arr_wr(arr_wr), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_ers(arr_ers), .arr_blk(arr_blk)
    );

    flash_array #(.AW(AW), .DW(DW), .BAW(BAW)) u_arr (
        .clk(clk), .rst(rst), .wr_en(arr_wr), .waddr(arr_addr),
        .wdata(arr_wdata), .ers_en(arr_ers), .ers_blk(arr_blk),
        .raddr(addr), .rdata(arr_rdata), .old_word(old_word)
    );

    always_comb begin
        unique case (mode)
            MODE_STATUS: rd_val = DW'(status);
            MODE_IDENT: begin
                if (addr == AW'(0))      rd_val = DW'(MFR_CODE);
                else if (addr == AW'(1)) rd_val = DW'(DEV_CODE);
                else                     rd_val = '0;
            end
            default:     rd_val = arr_rdata;
        endcase
    end

    assign data_oe = !rst && we_n && !ce_n && !oe_n;
    assign data_o  = data_oe ? rd_val : '0;

    AST_STATUS_READY_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (data_oe && mode == MODE_STATUS) |-> (data_o[7] == !busy)); // R4

endmodule

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;
    localparam int AW = 6, DW = 8, BAW = 4, PCYC = 4, ECYC = 20;
    localparam int DEPTH = 1 << AW;

    logic clk = 0, rst = 1, ce_n = 1, oe_n = 1, we_n = 1, vpp_ok = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] data_o;
    logic data_oe;

    int total = 0, fails = 0;
    string cur_req = "R1";

    flash_cmd_if #(.AW(AW), .DW(DW), .BAW(BAW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC),
                   .MFR_CODE(8'hA5), .DEV_CODE(8'h3C)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .vpp_ok(vpp_ok), .addr(addr), .wdata(wdata), .data_o(data_o), .data_oe(data_oe)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_mem [DEPTH];
    int m_mode = 0, m_seq = 0, m_rem = 0, m_op = 0, m_oa = 0, m_od = 0;
    bit m_e = 0, m_p = 0, m_l = 0, m_weq = 1;
    bit busy_pre, evt;
    int cmd, nv;

    initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;

    function automatic int m_status();
        return ((m_rem == 0) ? 128 : 0) + (m_e ? 32 : 0) + (m_p ? 16 : 0) + (m_l ? 8 : 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
            m_mode = 0; m_seq = 0; m_rem = 0; m_e = 0; m_p = 0; m_l = 0; m_weq = 1;
        end else begin
            busy_pre = (m_rem > 0);
            if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) begin
                    if (m_op == 0) begin
                        nv = m_mem[m_oa] & m_od;
                        if (nv != m_od) m_p = 1;
                        m_mem[m_oa] = nv;
                    end else begin
                        for (int i = 0; i < DEPTH; i++)
                            if ((i >> BAW) == (m_oa >> BAW)) m_mem[i] = 255;
                    end
                end
            end
            evt = we_n && !m_weq && !ce_n;
            cmd = int'(wdata);
            if (evt) begin
                if (busy_pre) begin
                    if (cmd == 'h70) m_mode = 1;
                end else if (m_seq == 1) begin
                    m_op = 0; m_oa = int'(addr); m_od = cmd; m_rem = PCYC;
                    m_mode = 1; m_seq = 0;
                end else if (m_seq == 2) begin
                    if (cmd == 'hD0) begin
                        m_op = 1; m_oa = int'(addr); m_rem = ECYC;
                    end else begin
                        m_e = 1; m_p = 1;
                    end
                    m_mode = 1; m_seq = 0;
                end else begin
                    case (cmd)
                        'hFF: m_mode = 0;
                        'h70: m_mode = 1;
                        'h90: m_mode = 2;
                        'h50: begin m_e = 0; m_p = 0; m_l = 0; end
                        'h40, 'h20: begin
                            m_mode = 1;
                            if (vpp_ok) m_seq = (cmd == 'h40) ? 1 : 2;
                            else m_l = 1;
                        end
                        default: ;
                    endcase
                end
            end
            m_weq = we_n;
        end
    end

    function automatic int m_read();
        if (m_mode == 1) return m_status();
        if (m_mode == 2) return (addr == 0) ? 'hA5 : (addr == 1) ? 'h3C : 0;
        return m_mem[addr];
    endfunction

    // per-cycle comparison against the model (R2 gating plus current-phase requirement)
    always @(negedge clk) begin
        bit eoe;
        int ed;
        eoe = !rst && we_n && !ce_n && !oe_n;
        ed  = eoe ? m_read() : 0;
        total++;
        if (data_oe !== eoe || int'(data_o) != ed) begin
            fails++;
            $display("FAIL %s/R2 model compare: actual oe=%0b data=%02h expected oe=%0b data=%02h",
                     cur_req, data_oe, data_o, eoe, ed);
        end
    end

    task automatic chk(string req, int got, int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic wr(int a, int d);
        ce_n = 0; oe_n = 1; we_n = 0; addr = AW'(a); wdata = DW'(d);
        @(negedge clk); #1; we_n = 1;
        @(negedge clk); #1; ce_n = 1;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
        @(negedge clk);
        chk(req, data_oe ? int'(data_o) : -1, exp);
        #1; ce_n = 1; oe_n = 1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog (all R): actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        idle(3); rst = 0; idle(1);
        cur_req = "R1";
        rd_chk("R1 array after reset", 3, 'hFF);
        wr(0, 'h70);
        rd_chk("R1 status after reset", 0, 'h80);
        wr(0, 'hFF);

        cur_req = "R2";
        ce_n = 0; oe_n = 1; we_n = 1; @(negedge clk); chk("R2 oe_n high", data_oe, 0); #1;
        ce_n = 1; oe_n = 0; @(negedge clk); chk("R2 ce_n high", data_oe, 0); #1;
        ce_n = 0; we_n = 0; @(negedge clk); chk("R2 we_n low", data_oe, 0); #1;
        ce_n = 1; oe_n = 1; idle(1); we_n = 1; idle(1);

        cur_req = "R6";
        wr(5, 'h40); wr(5, 'h3C);
        rd_chk("R6 busy status", 5, 'h00);
        cur_req = "R10";
        wr(5, 'hFF);
        idle(8);
        rd_chk("R10 FF while busy ignored", 9, 'h80);
        cur_req = "R3";
        wr(0, 'hFF);
        rd_chk("R3/R6 programmed word", 5, 'h3C);

        cur_req = "R7";
        wr(5, 'h40); wr(5, 'hC3); idle(8);
        rd_chk("R7 program error bit", 0, 'h90);
        wr(0, 'hFF);
        rd_chk("R7 AND result", 5, 'h00);
        cur_req = "R11";
        wr(0, 'h50); wr(0, 'h70);
        rd_chk("R11 cleared status", 0, 'h80);

        cur_req = "R5";
        wr(0, 'h90);
        rd_chk("R5 manufacturer", 0, 'hA5);
        rd_chk("R5 device", 1, 'h3C);
        rd_chk("R5 other offset", 2, 'h00);

        cur_req = "R8";
        wr(20, 'h40); wr(20, 'h11); idle(8);
        wr(4, 'h20); wr(4, 'hD0);
        rd_chk("R8 busy during erase", 0, 'h00);
        idle(ECYC + 4);
        rd_chk("R8 erase done status", 0, 'h80);
        wr(0, 'hFF);
        rd_chk("R8 erased word", 5, 'hFF);
        rd_chk("R8 other block kept", 20, 'h11);
        wr(20, 'h20); wr(20, 'h55);
        rd_chk("R8 sequence error", 0, 'hB0);
        wr(0, 'hFF);
        rd_chk("R8 no erase on bad confirm", 20, 'h11);
        wr(0, 'h50);

        cur_req = "R9";
        vpp_ok = 0; idle(1);
        wr(7, 'h40); wr(7, 'h00);
        rd_chk("R9 lockout status", 0, 'h88);
        wr(0, 'hFF);
        rd_chk("R9 word unchanged", 7, 'hFF);
        wr(16, 'h20); wr(16, 'hD0);
        wr(0, 'hFF);
        rd_chk("R9 erase rejected", 20, 'h11);
        wr(0, 'h70);
        rd_chk("R9/R4 status under lockout", 0, 'h88);
        wr(0, 'h50);
        rd_chk("R9/R11 clear under lockout", 0, 'h80);
        vpp_ok = 1; wr(0, 'hFF);

        cur_req = "R12";
        ce_n = 1; we_n = 0; addr = 0; wdata = 8'h70; idle(1); we_n = 1; idle(1);
        rd_chk("R12 strobe with ce_n high ignored", 20, 'h11);
        wr(0, 'h12);
        rd_chk("R12 unknown command ignored", 20, 'h11);

        cur_req = "R4";
        wr(0, 'h70);
        rd_chk("R4 status layout", 3, 'h80);

        idle(2);
        summary();
        $finish;
    end
endmodule